// File: doc/BRIEF.md
# Serial Protection-Status Write Controller

This block sits on the target side of a serial memory's SPI port and owns two bits of its status register. The first is the write-enable latch, which gates modifications. The second is the protection lock bit, which freezes the per-sector protection state. The block watches the chip select, serial clock and serial data lines and decodes two one-byte commands. Opcode 0x06 arms the write-enable latch. Opcode 0x01 carries one data byte that rewrites the lock bit and can ask the sector-protection array to protect or unprotect every sector at once. That request leaves the block as a single-cycle pulse with a flag that tells protect from unprotect.

The SPI lines are brought into the system clock domain through a synchronizer. Serial data is taken on rising serial-clock edges, MSB first, in SPI mode 0. Nothing changes until chip select returns high. At that moment the block checks the bit count, the opcode, the write-enable latch, the hardware write-protect input and the old lock value. It then either commits the new status or discards it.

Top module: `stsreg_wr_ctrl`

## Requirements
- R1: After reset, wel and lock are 0 and glb_pulse stays low.
- R2: A transfer made of exactly one byte equal to 0x06, closed by chip select high after bit 8, sets wel. The same opcode followed by any further bits leaves wel unchanged.
- R3: When wel is 1, opcode 0x01 followed by one data byte and closed on a byte boundary writes data bit 7 into lock and clears wel.
- R4: Opcode 0x01 issued while wel is 0 changes neither lock nor wel and produces no pulse.
- R5: If opcode 0x01 is closed before its data byte is complete, or after a bit count that is not a multiple of 8, lock keeps its value, no pulse occurs and wel is cleared.
- R6: Bytes sent after the first data byte of opcode 0x01 are ignored. The first data byte alone decides the result, provided chip select rises on a byte boundary.
- R7: While wr_prot is 1, a 0x01 command whose data bit 7 is 0 is ignored in full: lock is unchanged and no pulse occurs, but wel is cleared. A data bit 7 of 1 is still committed.
- R8: When a 0x01 command commits with data bits 5..2 equal to 1111 and the old lock equal to 0, glb_pulse is high for one cycle with glb_prot = 1.
- R9: When a 0x01 command commits with data bits 5..2 equal to 0000 and the old lock equal to 0, glb_pulse is high for one cycle with glb_prot = 0. Any other code, or an old lock of 1, produces no pulse.
- R10: Data is sampled on the rising serial-clock edge, MSB first. A final clock rise that reaches the block in the same system cycle as chip select going high still counts as a bit.
- R11: Any other opcode leaves wel and lock unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| sdi | input | 1 | SPI serial data into the block |
| wr_prot | input | 1 | Hardware write-protect, active high |
| wel | output | 1 | Write-enable latch |
| lock | output | 1 | Protection lock bit |
| glb_pulse | output | 1 | One-cycle global protect/unprotect request |
| glb_prot | output | 1 | Kind of the request: 1 protect, 0 unprotect |

## Verification
Two events can land in the same system cycle: the final serial-clock rise that completes a byte, and the chip-select rise that closes the transfer. The bench provokes this by driving sck high and cs_n high on the same clock tick, first for a write-enable and then for a status write. It judges the result by whether the command takes effect as a byte-aligned transfer. The commit cycle itself is a second collision, because it clears wel, updates lock and may fire the global pulse all at once. A pulse monitor counts every protect and unprotect pulse, and these counts are compared with a reference model after each transfer.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_WRSR = 8'h01;
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/srw_shifter.sv
module srw_shifter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [1:0]        byte_cnt,
  output logic [BYTE_W-1:0] opcode,
  output logic [BYTE_W-1:0] data
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg;
  logic [BYTE_W-1:0] full_byte;

  assign full_byte = {sreg[BYTE_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg     <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      data     <= '0;
    end else if (shift_en) begin
      sreg    <= full_byte;
      bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == LAST_BIT) begin
        if (byte_cnt == 2'd0) opcode <= full_byte;
        if (byte_cnt == 2'd1) data   <= full_byte;
        if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
      end
    end
  end
endmodule

// File: rtl/srw_commit.sv
module srw_commit
  import srw_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int LOCK_BIT = 7,
  parameter int CODE_HI = 5,
  parameter int CODE_LO = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_end,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [1:0]        byte_cnt,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] data,
  input  logic              wp,
  output logic              wel,
  output logic              lock,
  output logic              glb_pulse,
  output logic              glb_prot
);
  localparam int CODE_W = CODE_HI - CODE_LO + 1;

  logic [CODE_W-1:0] code;
  logic aligned, wren_ok, wrsr_seen, wrsr_full, blocked;
  logic wel_n, lock_n, pulse_n, prot_n;

  assign code      = data[CODE_HI:CODE_LO];
  assign aligned   = (bit_cnt == '0);
  assign wren_ok   = aligned && (byte_cnt == 2'd1) && (opcode == OPC_WREN);
  assign wrsr_seen = (byte_cnt != 2'd0) && (opcode == OPC_WRSR);
  assign wrsr_full = aligned && (byte_cnt >= 2'd2);
  assign blocked   = wp && !data[LOCK_BIT];

  always_comb begin
    wel_n   = wel;
    lock_n  = lock;
    pulse_n = 1'b0;
    prot_n  = glb_prot;
    if (cs_end) begin
      if (wren_ok) begin
        wel_n = 1'b1;
      end else if (wrsr_seen) begin
        wel_n = 1'b0;
        if (wrsr_full && wel && !blocked) begin
          lock_n = data[LOCK_BIT];
          if (!lock && (&code)) begin
            pulse_n = 1'b1;
            prot_n  = 1'b1;
          end else if (!lock && (code == '0)) begin
            pulse_n = 1'b1;
            prot_n  = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel       <= 1'b0;
      lock      <= 1'b0;
      glb_pulse <= 1'b0;
      glb_prot  <= 1'b0;
    end else begin
      wel       <= wel_n;
      lock      <= lock_n;
      glb_pulse <= pulse_n;
      glb_prot  <= prot_n;
    end
  end
endmodule

// File: rtl/stsreg_wr_ctrl.sv
module stsreg_wr_ctrl
  import srw_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int LOCK_BIT = 7,
  parameter int CODE_HI = 5,
  parameter int CODE_LO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic wr_prot,
  output logic wel,
  output logic lock,
  output logic glb_pulse,
  output logic glb_prot
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [3:0] pins_s;
  logic cs_s, sck_s, sdi_s, wp_s;
  logic sck_d, cs_d1, cs_d2;
  logic sck_rise, cs_end, idle;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        byte_cnt;
  logic [BYTE_W-1:0] opcode, data;

  srw_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, sdi, wr_prot}), .q(pins_s)
  );
  assign {cs_s, sck_s, sdi_s, wp_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d1 <= 1'b1;
      cs_d2 <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d1 <= cs_s;
      cs_d2 <= cs_d1;
    end
  end

  // Select is seen one cycle late, so a clock edge in its cycle counts.
  assign sck_rise = sck_s && !sck_d;
  assign cs_end   = cs_d1 && !cs_d2;
  assign idle     = cs_d1 && cs_d2;

  srw_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .clr(idle), .shift_en(sck_rise && !cs_d1),
    .sdi(sdi_s), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
    .opcode(opcode), .data(data)
  );

  srw_commit #(.CNT_W(CNT_W), .LOCK_BIT(LOCK_BIT), .CODE_HI(CODE_HI),
               .CODE_LO(CODE_LO)) u_commit (
    .clk(clk), .rst(rst), .cs_end(cs_end), .bit_cnt(bit_cnt),
    .byte_cnt(byte_cnt), .opcode(opcode), .data(data), .wp(wp_s),
    .wel(wel), .lock(lock), .glb_pulse(glb_pulse), .glb_prot(glb_prot)
  );
endmodule

// File: rtl/srw_checker.sv
module srw_checker (
  input logic clk,
  input logic rst,
  input logic wp_s,
  input logic wel,
  input logic lock,
  input logic glb_pulse,
  input logic glb_prot
);
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    glb_pulse |=> !glb_pulse);

  assert_lock_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock) |-> $past(wel));

  assert_no_clear_under_wp_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> !$past(wp_s));

  assert_pulse_old_lock_R9: assert property (@(posedge clk) disable iff (rst)
    glb_pulse |-> !$past(lock));

  assert_pulse_clears_wel_R3: assert property (@(posedge clk) disable iff (rst)
    glb_pulse |-> $fell(wel));

  assert_wel_set_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> (!glb_pulse && $stable(lock)));

  assert_prot_flag_known_R8: assert property (@(posedge clk) disable iff (rst)
    glb_pulse |-> !$isunknown(glb_prot));
endmodule

bind stsreg_wr_ctrl srw_checker i_srw_checker (
  .clk(clk), .rst(rst), .wp_s(wp_s), .wel(wel), .lock(lock),
  .glb_pulse(glb_pulse), .glb_prot(glb_prot)
);

// File: tb/test_stsreg_wr_ctrl.sv
`timescale 1ns/1ps
module test_stsreg_wr_ctrl;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wr_prot = 1'b0;
  logic wel, lock, glb_pulse, glb_prot;

  int checks = 0, errors = 0;
  int prot_cnt = 0, unprot_cnt = 0;
  bit m_wel = 1'b0, m_lock = 1'b0;
  int e_prot = 0, e_unprot = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stsreg_wr_ctrl i_stsreg_wr_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wr_prot(wr_prot), .wel(wel), .lock(lock),
    .glb_pulse(glb_pulse), .glb_prot(glb_prot)
  );

  always @(negedge clk)
    if (!rst && glb_pulse) begin
      if (glb_prot) prot_cnt++;
      else unprot_cnt++;
    end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] v, input int n, input bit same);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = v[31-i];
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      if (same && i == n - 1) begin
        cs_n = 1'b1;
      end else begin
        repeat (HP) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (HP) @(negedge clk);
    sck  = 1'b0;
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // Reference model of the requirements, then compare at the ports.
  task automatic do_cmd(input string tag, input logic [31:0] v, input int n,
                        input bit same);
    logic [7:0] op, dat;
    bit aligned;
    op = v[31:24];
    dat = v[23:16];
    aligned = (n % 8) == 0;
    if (n >= 8) begin
      if (op == 8'h06) begin
        if (aligned && n == 8) m_wel = 1'b1;
      end else if (op == 8'h01) begin
        if (aligned && n >= 16 && m_wel && !(wr_prot && !dat[7])) begin
          if (!m_lock && dat[5:2] == 4'hF) e_prot++;
          if (!m_lock && dat[5:2] == 4'h0) e_unprot++;
          m_lock = dat[7];
        end
        m_wel = 1'b0;
      end
    end
    xfer(v, n, same);
    chk({tag, " wel"}, int'(wel), int'(m_wel));
    chk({tag, " lock"}, int'(lock), int'(m_lock));
    chk({tag, " protect pulses"}, prot_cnt, e_prot);
    chk({tag, " unprotect pulses"}, unprot_cnt, e_unprot);
  endtask

  task automatic t_reset;
    chk("R1 wel", int'(wel), 0);
    chk("R1 lock", int'(lock), 0);
    chk("R1 pulses", prot_cnt + unprot_cnt, 0);
  endtask

  task automatic t_wren;
    do_cmd("R2 wren 9 bits", 32'h0600_0000, 9, 1'b0);
    do_cmd("R2 wren 16 bits", 32'h0600_0000, 16, 1'b0);
    do_cmd("R2 wren", 32'h0600_0000, 8, 1'b0);
  endtask

  task automatic t_commit;
    do_cmd("R3 wrsr 0x80", 32'h0180_0000, 16, 1'b0);
    do_cmd("R4 wrsr without wel", 32'h0100_0000, 16, 1'b0);
    do_cmd("R3 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R9 clear with old lock 1", 32'h0100_0000, 16, 1'b0);
  endtask

  task automatic t_abort;
    do_cmd("R5 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R5 opcode only", 32'h01FC_0000, 8, 1'b0);
    do_cmd("R5 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R5 13 bits", 32'h01FC_0000, 13, 1'b0);
    do_cmd("R5 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R5 20 bits", 32'h01FC_0000, 20, 1'b0);
  endtask

  task automatic t_global;
    do_cmd("R8 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R8 protect code", 32'h013C_0000, 16, 1'b0);
    do_cmd("R9 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R9 mixed code", 32'h0114_0000, 16, 1'b0);
    do_cmd("R6 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R6 extra byte", 32'h013C_8000, 24, 1'b0);
  endtask

  task automatic t_wp;
    wr_prot = 1'b1;
    do_cmd("R7 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R7 clear blocked at 0", 32'h0100_0000, 16, 1'b0);
    do_cmd("R7 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R7 set allowed", 32'h0180_0000, 16, 1'b0);
    do_cmd("R7 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R7 clear blocked at 1", 32'h0100_0000, 16, 1'b0);
    wr_prot = 1'b0;
    do_cmd("R7 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R7 clear after release", 32'h0100_0000, 16, 1'b0);
  endtask

  task automatic t_edge;
    do_cmd("R10 wren same edge", 32'h0600_0000, 8, 1'b1);
    do_cmd("R10 wrsr same edge", 32'h0180_0000, 16, 1'b1);
    do_cmd("R10 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R10 wrsr 15 bits", 32'h0100_0000, 15, 1'b1);
  endtask

  task automatic t_other;
    do_cmd("R11 wren", 32'h0600_0000, 8, 1'b0);
    do_cmd("R11 opcode 0x05", 32'h0500_0000, 16, 1'b0);
    do_cmd("R11 opcode 0x81", 32'h8100_0000, 16, 1'b0);
    do_cmd("R11 wrsr", 32'h0100_0000, 16, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_wren();
    t_commit();
    t_abort();
    t_global();
    t_wp();
    t_edge();
    t_other();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule